// File: doc/BRIEF.md
# Compare-Match PWM Channel

This block is a single timer channel that builds a pulse-width-modulated output by scheduling absolute edge times against one of two free-running 16-bit timebases supplied from outside. It has no reload counter. At every rising edge the channel records the time of that rise. It then derives the next falling edge by adding the high time, and the next rising edge by adding the period. An output edge occurs in the clock cycle in which the selected timebase equals the scheduled value. All sums wrap modulo 2^16, so the timebase may roll over freely.

A host talks to the channel through a small register port: a write strobe with a 3-bit address and 32-bit data, and a combinational read port. The host sets the period and the high time, either separately or both at once in one write. It then posts a 2-bit service request, either to start the channel or to apply new values without waiting for the next rise. Values written without a request take effect at the next scheduled rise. Two extra behaviours follow from the high time and period. When the high time is zero the channel holds 0% duty, and when the period is at or below a nonzero high time it holds 100% duty. In both of these level cases the channel keeps scheduling rise events but makes no pin transitions. An optional flag marks the start of each period.

The scheduler is a state machine with five states. ST_IDLE waits for a start request. ST_HIGH waits for the fall match. ST_LOW waits for the rise match. ST_LEVEL waits for the rise match with the pin held. ST_DROP lasts one cycle and forces a fall that an immediate update has left behind. The transitions are as follows:
- Start: any state goes to ST_HIGH, or to ST_LEVEL in a level case.
- Fall match: ST_HIGH goes to ST_LOW.
- Rise match: ST_LOW or ST_LEVEL goes to ST_HIGH or ST_LEVEL.
- Immediate update: any running state goes to ST_HIGH, ST_DROP, ST_LOW or ST_LEVEL.
- Forced fall: ST_DROP goes to ST_LOW.

Top module: `pwm_cm_channel`

## Requirements
- R1: Synchronous active-high reset clears every register, drives `pwm_out` and `irq` low, and leaves the channel idle. The output stays low, even while enabled, until a start request is served.
- R2: The service request register is at address 4 and holds a 2-bit code in data[1:0]. Code 2'b10 is a start request; it is visible on a read until served. The request is served on the clock edge after it is written, provided the channel is enabled, and the register then reads 2'b00. Serving a start records the current timebase as the last rise (read address 6) and stores last rise + period as the next rise (read address 7). It drives the pin high if the high time is nonzero and low otherwise.
- R3: With 0 < high time < period (normal mode), `pwm_out` is high for exactly high-time clock cycles and low for exactly period − high-time cycles. The timebase advances by one count per clock.
- R4: The high time is at address 1 and the period at address 2, each in data[15:0]. Address 3 writes both registers in the same cycle, with the high time in data[31:16] and the period in data[15:0]. Values written without a request leave the waveform in progress untouched and take effect from the next rise.
- R5: A high time of 0 gives constant low output. Rise events still occur every period, and the last-rise value advances by the period each time.
- R6: A nonzero high time with period ≤ high time gives constant high output.
- R7: Code 2'b01 is an immediate update. It recomputes the fall as last rise + high time and the next rise as last rise + period. If less time has passed since the last rise than the new high time, the pin is high until the new fall.
- R8: On an immediate update whose recomputed fall has already passed while the pin is high, the pin goes low on the clock after the request is served. The following low time runs to the recomputed rise.
- R9: The control register is at address 0. Bit 5 of it is the interrupt enable. While that bit is set, every rise event (level modes included), every start and every immediate update sets the flag driven on `irq`. Writing 1 to bit 0 of address 5 clears the flag. While the enable bit is clear, the flag is not set.
- R10: Control bits [3:0] select the timebase: 4'h7 selects `tb_b`, and 4'h4 (or any other value) selects `tb_a`.
- R11: A write of the reserved code 2'b11 to the request register is ignored. The register keeps reading 2'b00 and the waveform continues unchanged.
- R12: Control bit 4 enables the channel. While it is clear, no edge is scheduled and no request is served; the pin and the rise registers hold their values and a posted request stays pending. When the bit is set again, the pending request is served.
- R13: Time sums wrap modulo 2^16, so a waveform started near 16'hFFFF keeps exact high and low times across the rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_a | input | 16 | First free-running timebase |
| tb_b | input | 16 | Second free-running timebase |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data |
| pwm_out | output | 1 | PWM waveform output |
| irq | output | 1 | Period-start / update flag |

## Verification
A register write is captured on the first edge after the strobe is driven. A request therefore takes effect on the second edge, and the bench reads the pending code between those two edges and the cleared code after the second. Edges scheduled against the timebase appear in the cycle in which the timebase equals the stored time. The bench therefore measures run lengths of `pwm_out`, sampled on falling clock edges, starting from the sample right after a detected rise. For immediate updates it counts the two samples already spent on the two register writes, so the expected high runs are seven and four cycles. The flag is sampled in the half cycle after the rise edge that sets it, and after the write edge that clears it.

// File: rtl/pwm_cm_pkg.sv
package pwm_cm_pkg;

    // register addresses
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_HIGH = 3'd1;
    localparam logic [2:0] A_PER  = 3'd2;
    localparam logic [2:0] A_BOTH = 3'd3;
    localparam logic [2:0] A_SVC  = 3'd4;
    localparam logic [2:0] A_FLAG = 3'd5;
    localparam logic [2:0] A_OLD  = 3'd6;
    localparam logic [2:0] A_NEXT = 3'd7;

    // service request codes
    localparam logic [1:0] SVC_NONE = 2'b00;
    localparam logic [1:0] SVC_IMM  = 2'b01;
    localparam logic [1:0] SVC_INIT = 2'b10;
    localparam logic [1:0] SVC_RSVD = 2'b11;

    // timebase select codes
    localparam logic [3:0] TBSEL_A = 4'h4;
    localparam logic [3:0] TBSEL_B = 4'h7;

    // control register layout
    localparam int CTRL_W     = 6;
    localparam int CTRL_EN    = 4;
    localparam int CTRL_IRQEN = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIGH,
        ST_LOW,
        ST_LEVEL,
        ST_DROP
    } ch_state_e;

endpackage

// File: rtl/pwm_cm_regs.sv
module pwm_cm_regs
    import pwm_cm_pkg::*;
#(
    parameter int TW = 16,
    localparam int DW = 2 * TW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [2:0]    rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          svc_ack,
    input  logic          irq_evt,
    input  logic [TW-1:0] old_rise,
    input  logic [TW-1:0] next_rise,
    output logic [TW-1:0] hi_q,
    output logic [TW-1:0] per_q,
    output logic [3:0]    tbsel_q,
    output logic          ch_en,
    output logic          irq_en,
    output logic [1:0]    svc_q,
    output logic          flag_q
);

    logic [CTRL_W-1:0] ctrl_q;
    logic wr_ctrl, wr_hi, wr_per, wr_both, wr_svc, wr_flag;

    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign wr_hi   = wr_en && (wr_addr == A_HIGH);
    assign wr_per  = wr_en && (wr_addr == A_PER);
    assign wr_both = wr_en && (wr_addr == A_BOTH);
    assign wr_svc  = wr_en && (wr_addr == A_SVC);
    assign wr_flag = wr_en && (wr_addr == A_FLAG);

    assign tbsel_q = ctrl_q[3:0];
    assign ch_en   = ctrl_q[CTRL_EN];
    assign irq_en  = ctrl_q[CTRL_IRQEN];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            hi_q   <= '0;
            per_q  <= '0;
            svc_q  <= SVC_NONE;
            flag_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= wr_data[CTRL_W-1:0];
            end
            // both halves land on the same edge when written together
            if (wr_hi) begin
                hi_q <= wr_data[TW-1:0];
            end else if (wr_both) begin
                hi_q <= wr_data[DW-1:TW];
            end
            if (wr_per || wr_both) begin
                per_q <= wr_data[TW-1:0];
            end
            // a fresh host code wins over the acknowledge; reserved code dropped
            if (wr_svc && (wr_data[1:0] != SVC_RSVD)) begin
                svc_q <= wr_data[1:0];
            end else if (svc_ack) begin
                svc_q <= SVC_NONE;
            end
            if (irq_evt && irq_en) begin
                flag_q <= 1'b1;
            end else if (wr_flag && wr_data[0]) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_CTRL: rd_data = {{(DW-CTRL_W){1'b0}}, ctrl_q};
            A_HIGH: rd_data = {{TW{1'b0}}, hi_q};
            A_PER:  rd_data = {{TW{1'b0}}, per_q};
            A_BOTH: rd_data = {hi_q, per_q};
            A_SVC:  rd_data = {{(DW-2){1'b0}}, svc_q};
            A_FLAG: rd_data = {{(DW-1){1'b0}}, flag_q};
            A_OLD:  rd_data = {{TW{1'b0}}, old_rise};
            A_NEXT: rd_data = {{TW{1'b0}}, next_rise};
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pwm_cm_tbmux.sv
module pwm_cm_tbmux
    import pwm_cm_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic [3:0]    tbsel,
    input  logic [TW-1:0] tb_a,
    input  logic [TW-1:0] tb_b,
    output logic [TW-1:0] tb_now
);

    // only the second code steers to tb_b; everything else keeps tb_a
    assign tb_now = (tbsel == TBSEL_B) ? tb_b : tb_a;

endmodule

// File: rtl/pwm_cm_sched.sv
module pwm_cm_sched
    import pwm_cm_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [TW-1:0] tb_now,
    input  logic [TW-1:0] hi,
    input  logic [TW-1:0] per,
    input  logic [1:0]    svc,
    output logic          pwm,
    output logic [TW-1:0] old_rise,
    output logic [TW-1:0] next_rise,
    output logic          svc_ack,
    output logic          irq_evt
);

    ch_state_e     state_q, state_d;
    logic [TW-1:0] fall_q, fall_d;
    logic [TW-1:0] old_d, rise_d;
    logic          pin_d;

    logic          lvl_mode;
    logic          lvl_pin;
    logic [TW-1:0] elapsed;
    logic          hit_fall;
    logic          hit_rise;

    assign lvl_mode = (hi == '0) || (per <= hi);
    assign lvl_pin  = (hi != '0);
    assign elapsed  = tb_now - old_rise;
    assign hit_fall = (tb_now == fall_q);
    assign hit_rise = (tb_now == next_rise);

    always_comb begin
        state_d = state_q;
        pin_d   = pwm;
        old_d   = old_rise;
        fall_d  = fall_q;
        rise_d  = next_rise;
        svc_ack = 1'b0;
        irq_evt = 1'b0;
        if (en) begin
            if (svc == SVC_INIT) begin
                svc_ack = 1'b1;
                irq_evt = 1'b1;
                old_d   = tb_now;
                fall_d  = tb_now + hi;
                rise_d  = tb_now + per;
                pin_d   = lvl_pin;
                state_d = lvl_mode ? ST_LEVEL : ST_HIGH;
            end else if (svc == SVC_IMM) begin
                svc_ack = 1'b1;
                if (state_q != ST_IDLE) begin
                    irq_evt = 1'b1;
                    fall_d  = old_rise + hi;
                    rise_d  = old_rise + per;
                    if (lvl_mode) begin
                        pin_d   = lvl_pin;
                        state_d = ST_LEVEL;
                    end else if (elapsed < hi) begin
                        pin_d   = 1'b1;
                        state_d = ST_HIGH;
                    end else if (pwm) begin
                        state_d = ST_DROP;
                    end else begin
                        state_d = ST_LOW;
                    end
                end
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        state_d = ST_IDLE;
                    end
                    ST_HIGH: begin
                        if (hit_fall) begin
                            pin_d   = 1'b0;
                            state_d = ST_LOW;
                        end
                    end
                    ST_LOW, ST_LEVEL: begin
                        if (hit_rise) begin
                            irq_evt = 1'b1;
                            old_d   = next_rise;
                            fall_d  = next_rise + hi;
                            rise_d  = next_rise + per;
                            pin_d   = lvl_pin;
                            state_d = lvl_mode ? ST_LEVEL : ST_HIGH;
                        end
                    end
                    ST_DROP: begin
                        pin_d   = 1'b0;
                        state_d = ST_LOW;
                    end
                    default: begin
                        state_d = ST_IDLE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm       <= 1'b0;
            old_rise  <= '0;
            next_rise <= '0;
            fall_q    <= '0;
        end else begin
            pwm       <= pin_d;
            old_rise  <= old_d;
            next_rise <= rise_d;
            fall_q    <= fall_d;
        end
    end

endmodule

// File: rtl/pwm_cm_channel.sv
module pwm_cm_channel
    import pwm_cm_pkg::*;
#(
    parameter int TW = 16,
    localparam int DW = 2 * TW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] tb_a,
    input  logic [TW-1:0] tb_b,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [2:0]    rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          pwm_out,
    output logic          irq
);

    logic [TW-1:0] hi_q, per_q, tb_now, old_rise, next_rise;
    logic [3:0]    tbsel_q;
    logic          ch_en, irq_en, flag_q, svc_ack, irq_evt;
    logic [1:0]    svc_q;

    pwm_cm_regs #(.TW(TW)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .svc_ack   (svc_ack),
        .irq_evt   (irq_evt),
        .old_rise  (old_rise),
        .next_rise (next_rise),
        .hi_q      (hi_q),
        .per_q     (per_q),
        .tbsel_q   (tbsel_q),
        .ch_en     (ch_en),
        .irq_en    (irq_en),
        .svc_q     (svc_q),
        .flag_q    (flag_q)
    );

    pwm_cm_tbmux #(.TW(TW)) tbmux_i (
        .tbsel  (tbsel_q),
        .tb_a   (tb_a),
        .tb_b   (tb_b),
        .tb_now (tb_now)
    );

    pwm_cm_sched #(.TW(TW)) sched_i (
        .clk       (clk),
        .rst       (rst),
        .en        (ch_en),
        .tb_now    (tb_now),
        .hi        (hi_q),
        .per       (per_q),
        .svc       (svc_q),
        .pwm       (pwm_out),
        .old_rise  (old_rise),
        .next_rise (next_rise),
        .svc_ack   (svc_ack),
        .irq_evt   (irq_evt)
    );

    assign irq = flag_q;

endmodule

// File: rtl/pwm_cm_channel_chk.sv
module pwm_cm_channel_chk
    import pwm_cm_pkg::*;
#(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [2:0]    wr_addr,
    input logic          pwm_out,
    input logic          irq,
    input logic [1:0]    svc_q,
    input logic          ch_en,
    input logic          irq_en,
    input logic [TW-1:0] old_rise
);

    // R1: one cycle after reset the output and flag are low
    a_r1_reset_low: assert property (@(posedge clk)
        $past(rst) |-> (!pwm_out && !irq));

    // R2: a pending request on an enabled channel is cleared on the next edge
    a_r2_request_served: assert property (@(posedge clk) disable iff (rst)
        ((svc_q != SVC_NONE) && ch_en && !(wr_en && (wr_addr == A_SVC)))
        |=> (svc_q == SVC_NONE));

    // R11: the reserved code never reaches the request register
    a_r11_no_reserved: assert property (@(posedge clk) disable iff (rst)
        svc_q != SVC_RSVD);

    // R9: the flag rises only while interrupts are enabled
    a_r9_flag_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(irq_en));

    // R12: a disabled channel holds its pin and rise time
    a_r12_hold_pin: assert property (@(posedge clk) disable iff (rst)
        !ch_en |=> $stable(pwm_out));

    a_r12_hold_rise: assert property (@(posedge clk) disable iff (rst)
        !ch_en |=> $stable(old_rise));

endmodule

bind pwm_cm_channel pwm_cm_channel_chk #(.TW(TW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .pwm_out  (pwm_out),
    .irq      (irq),
    .svc_q    (svc_q),
    .ch_en    (ch_en),
    .irq_en   (irq_en),
    .old_rise (old_rise)
);

// File: tb/pwm_cm_channel_tb_top.sv
module pwm_cm_channel_tb_top;
    import pwm_cm_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tb_a = 16'd0;
    logic [15:0] tb_b = 16'd0;
    logic        tba_load = 1'b0;
    logic [15:0] tba_val = 16'd0;
    logic        tbb_run = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic [2:0]  rd_addr = 3'd0;
    logic [31:0] rd_data;
    logic        pwm_out;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (tba_load) tb_a <= tba_val;
        else          tb_a <= tb_a + 16'd1;
        if (tbb_run)  tb_b <= tb_b + 16'd1;
    end

    pwm_cm_channel dut_i (
        .clk     (clk),
        .rst     (rst),
        .tb_a    (tb_a),
        .tb_b    (tb_b),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pwm_out (pwm_out),
        .irq     (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sync_to(input logic lvl);
        int g = 0;
        while (pwm_out == lvl && g < 1000) begin g++; @(negedge clk); end
        while (pwm_out != lvl && g < 2000) begin g++; @(negedge clk); end
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (pwm_out == lvl && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic count_level(input logic lvl, input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out == lvl) hits++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int v;
        chk("R1 pin after reset", int'(pwm_out), 0);
        chk("R1 irq after reset", int'(irq), 0);
        rd(A_SVC, v);  chk("R1 request after reset", v, 0);
        rd(A_OLD, v);  chk("R1 last rise after reset", v, 0);
        wr(A_CTRL, 32'h14);
        count_level(1'b1, 20, v);
        chk("R1 idle output stays low", v, 0);
    endtask

    task automatic t_init();
        int v, o, nx, n;
        wr(A_BOTH, {16'd8, 16'd20});
        wr(A_SVC, 32'h2);
        rd(A_SVC, v); chk("R2 start pending", v, 2);
        cyc(1);
        rd(A_SVC, v); chk("R2 start cleared", v, 0);
        chk("R2 pin high after start", int'(pwm_out), 1);
        rd(A_OLD, o); rd(A_NEXT, nx);
        chk("R2 next minus last rise", (nx - o) & 16'hFFFF, 20);
        run_len(1'b1, n); chk("R3 high run", n, 8);
        run_len(1'b0, n); chk("R3 low run", n, 12);
    endtask

    task automatic t_deferred();
        int n;
        sync_to(1'b0);
        wr(A_BOTH, {16'd5, 16'd10});
        run_len(1'b0, n); chk("R4 current low run kept", n + 1, 12);
        run_len(1'b1, n); chk("R4 new high run", n, 5);
        run_len(1'b0, n); chk("R4 new low run", n, 5);
    endtask

    task automatic t_irq();
        wr(A_CTRL, 32'h34);
        sync_to(1'b1);
        chk("R9 flag set at rise", int'(irq), 1);
        wr(A_FLAG, 32'h1);
        chk("R9 flag cleared by write", int'(irq), 0);
        sync_to(1'b1);
        chk("R9 flag set at next rise", int'(irq), 1);
        wr(A_CTRL, 32'h14);
        wr(A_FLAG, 32'h1);
        sync_to(1'b1);
        chk("R9 no flag when disabled", int'(irq), 0);
        wr(A_CTRL, 32'h34);
    endtask

    task automatic t_level0();
        int v, o1, o2;
        sync_to(1'b0);
        wr(A_BOTH, {16'd0, 16'd10});
        cyc(12);
        count_level(1'b1, 30, v);
        chk("R5 zero duty never high", v, 0);
        rd(A_OLD, o1);
        cyc(10);
        rd(A_OLD, o2);
        chk("R5 rise advances by period", (o2 - o1) & 16'hFFFF, 10);
        wr(A_FLAG, 32'h1);
        cyc(10);
        chk("R9 flag set in level mode", int'(irq), 1);
    endtask

    task automatic t_level100();
        int v;
        wr(A_BOTH, {16'd12, 16'd10});
        cyc(12);
        count_level(1'b0, 30, v);
        chk("R6 full duty never low", v, 0);
    endtask

    task automatic t_immediate();
        int n;
        wr(A_BOTH, {16'd5, 16'd10});
        sync_to(1'b1);
        wr(A_BOTH, {16'd7, 16'd10});
        wr(A_SVC, 32'h1);
        run_len(1'b1, n); chk("R7 high stretched to new fall", n + 2, 7);
        run_len(1'b0, n); chk("R7 low run after stretch", n, 3);
        sync_to(1'b1);
        wr(A_BOTH, {16'd2, 16'd10});
        wr(A_SVC, 32'h1);
        run_len(1'b1, n); chk("R8 passed fall taken next clock", n + 2, 4);
        run_len(1'b0, n); chk("R8 low run to recomputed rise", n, 6);
    endtask

    task automatic t_reserved();
        int v, n;
        wr(A_SVC, 32'h3);
        rd(A_SVC, v); chk("R11 reserved code ignored", v, 0);
        sync_to(1'b1);
        run_len(1'b1, n); chk("R11 waveform unchanged", n, 2);
    endtask

    task automatic t_freeze();
        int v, o1, o2;
        logic p;
        wr(A_CTRL, 32'h24);
        p = pwm_out;
        rd(A_OLD, o1);
        count_level(~p, 40, v);
        chk("R12 pin held while disabled", v, 0);
        rd(A_OLD, o2);
        chk("R12 last rise held", o2, o1);
        wr(A_SVC, 32'h2);
        cyc(3);
        rd(A_SVC, v); chk("R12 request stays pending", v, 2);
        wr(A_CTRL, 32'h34);
        cyc(1);
        rd(A_SVC, v); chk("R12 request served on enable", v, 0);
        chk("R12 pin high after served start", int'(pwm_out), 1);
    endtask

    task automatic t_tbsel();
        int v, n;
        tbb_run = 1'b0;
        wr(A_CTRL, 32'h37);
        wr(A_SVC, 32'h2);
        cyc(1);
        chk("R10 started on second timebase", int'(pwm_out), 1);
        count_level(1'b0, 30, v);
        chk("R10 frozen second timebase gives no edge", v, 0);
        tbb_run = 1'b1;
        sync_to(1'b1);
        run_len(1'b1, n); chk("R10 high run on second timebase", n, 2);
        run_len(1'b0, n); chk("R10 low run on second timebase", n, 8);
    endtask

    task automatic t_wrap();
        int v, n;
        wr(A_CTRL, 32'h34);
        wr(A_BOTH, {16'd8, 16'd20});
        tba_val  = 16'hFFF8;
        tba_load = 1'b1;
        wr(A_SVC, 32'h2);
        tba_load = 1'b0;
        cyc(1);
        rd(A_OLD, v);  chk("R13 last rise near top", v, 16'hFFF8);
        rd(A_NEXT, v); chk("R13 next rise wrapped", v, 16'h000C);
        run_len(1'b1, n); chk("R13 high run across wrap", n, 8);
        run_len(1'b0, n); chk("R13 low run across wrap", n, 12);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_init();
        t_deferred();
        t_irq();
        t_level0();
        t_level100();
        t_immediate();
        t_reserved();
        t_freeze();
        t_tbsel();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule